// File: doc/BRIEF.md
# I/O Cycle Arbiter With Mirrored Internal Accesses

This block takes I/O requests from a processor core and decides, for each one, whether it lands in the on-chip peripheral register window or goes only to the external bus. The window is 64 registers deep. The low six address bits pick the register. The next two bits must equal a software-set relocation base, and the upper address byte must be zero. A page-zero request flag clears the upper byte before decoding, so the dedicated page-zero instructions can reach the window.

Every access drives a cycle on the external bus. An internal hit strobes the register file and also places a mirrored cycle on the bus, with the same address and, for writes, the same data. That mirrored cycle always runs at the fixed internal length. The programmed wait-state count, the external WAIT pin and the data on the external read bus all have no effect on it. A miss becomes a plain external cycle. It is stretched first by the programmed wait states and then by WAIT.

The core holds `req_valid` and the request fields steady until `req_ready` pulses. The wait-state count is taken when the request is accepted. The relocation base can be written at any time, but it only affects requests accepted after the write.

Top module: `iocyc_arbiter`

## Requirements
- R1: A request is internal exactly when its effective address has bits [15:8] equal to zero and bits [7:6] equal to the relocation base. The register index is bits [5:0]. Any other address is external.
- R2: When `req_page0` is 1, bits [15:8] of the effective address are zero, both for decoding and on `ext_addr`. Otherwise the effective address is `req_addr`.
- R3: An internal write pulses `reg_sel` with `reg_we`=1 for exactly one cycle, carrying the index and the write data. While `ext_cyc` is high, the same request drives `ext_write`=1 with the same address and data.
- R4: An internal read also drives an external read cycle (`ext_cyc`=1, `ext_write`=0). The returned `rsp_rdata` is the `reg_rdata` value, and `ext_rdata` is discarded.
- R5: An internal access raises `req_ready` on the third rising edge counted from the accepting edge, whatever the values of `wait_cnt` and `ext_wait`.
- R6: An external access runs for `3 + wait_cnt + k` edges, where k is the number of cycles `ext_wait` is high after the wait states have elapsed. It never pulses `reg_sel` and returns `ext_rdata` on reads. An external write leaves the internal registers unchanged.
- R7: `req_ready` is high for exactly one cycle per accepted request.
- R8: The relocation base resets to 0 and is loaded from `base_wdata` when `base_wr` is high. A change made while a cycle is in progress does not alter that cycle's decode; it applies from the next accepted request.
- R9: After reset, `req_ready`, `ext_cyc` and `reg_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | I/O request from core, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_page0 | input | 1 | Clear upper address byte (page-zero instruction) |
| req_addr | input | 16 | I/O address |
| req_wdata | input | 8 | Write data |
| wait_cnt | input | 2 | Programmed wait states for external cycles |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read result, valid with req_ready |
| base_wr | input | 1 | Load relocation base |
| base_wdata | input | 2 | New relocation base |
| reg_sel | output | 1 | Register file strobe, internal hits only |
| reg_we | output | 1 | Register file write enable |
| reg_idx | output | 6 | Register index |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data for reg_idx |
| ext_cyc | output | 1 | External bus cycle active |
| ext_write | output | 1 | External cycle is a write |
| ext_addr | output | 16 | External bus address |
| ext_wdata | output | 8 | External bus write data |
| ext_rdata | input | 8 | External bus read data |
| ext_wait | input | 1 | External WAIT, extends external cycles |

## Verification
The bench holds WAIT high for several cycles and programs three wait states during internal accesses. A design that let either one reach the mirrored cycle would return `req_ready` late. Internal reads are made where the external bus returns a value different from the register. A design that muxed the wrong source would return the bus byte. Other tests rewrite the relocation base in the middle of an internal cycle, use page-zero requests whose upper byte is not zero, and make addresses that match the window in every bit except the two relocation bits. These catch a decode done at the wrong moment or done on the raw address. An external write to an address whose low bits alias a register, followed by an internal read, exposes a register file strobed on a miss.

// File: rtl/iocyc_pkg.sv
package iocyc_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int IDX_W  = 6;
    localparam int BASE_W = 2;
    localparam int WS_W   = 2;
    localparam int PAGE_W = ADDR_W - IDX_W - BASE_W;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_LEAD,
        CS_WS,
        CS_DATA,
        CS_ACK
    } cyc_state_e;

    typedef struct packed {
        logic              wr;
        logic              intl;
        logic [WS_W-1:0]   ws;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } io_req_t;

    function automatic logic [ADDR_W-1:0] page_force(input logic [ADDR_W-1:0] a,
                                                     input logic pg0);
        logic [ADDR_W-1:0] r;
        r = a;
        if (pg0) r[ADDR_W-1 -: PAGE_W] = '0;
        return r;
    endfunction

    function automatic logic window_hit(input logic [ADDR_W-1:0] a,
                                        input logic [BASE_W-1:0] base);
        return (a[ADDR_W-1 -: PAGE_W] == '0) && (a[IDX_W +: BASE_W] == base);
    endfunction
endpackage

// File: rtl/iocyc_window.sv
module iocyc_window
    import iocyc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              base_wr,
    input  logic [BASE_W-1:0] base_wdata,
    input  logic [ADDR_W-1:0] raw_addr,
    input  logic              page0,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              hit
);
    logic [BASE_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst)          base_q <= '0;
        else if (base_wr) base_q <= base_wdata;
    end

    always_comb begin
        eff_addr = page_force(raw_addr, page0);
        hit      = window_hit(eff_addr, base_q);
    end

    // R8: the base moves only on a write strobe
    assert_base_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !base_wr |=> $stable(base_q));
endmodule

// File: rtl/iocyc_timer.sv
module iocyc_timer
    import iocyc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            intl,
    input  logic [WS_W-1:0] ws,
    input  logic            ext_wait,
    output cyc_state_e      state
);
    cyc_state_e      state_d;
    logic [WS_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state;
        cnt_d   = cnt_q;
        unique case (state)
            CS_IDLE: if (start) state_d = CS_LEAD;
            CS_LEAD: begin
                if (!intl && ws != '0) begin
                    state_d = CS_WS;
                    cnt_d   = ws - 1'b1;
                end else begin
                    state_d = CS_DATA;
                end
            end
            CS_WS: begin
                if (cnt_q == '0) state_d = CS_DATA;
                else             cnt_d   = cnt_q - 1'b1;
            end
            CS_DATA: begin
                if (intl)           state_d = CS_ACK;
                else if (!ext_wait) state_d = CS_ACK;
            end
            CS_ACK:  state_d = CS_IDLE;
            default: state_d = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CS_IDLE;
            cnt_q <= '0;
        end else begin
            state <= state_d;
            cnt_q <= cnt_d;
        end
    end

    // R5: the mirrored cycle never stretches on WAIT
    assert_int_fixed_R5: assert property (@(posedge clk) disable iff (rst)
        (state == CS_DATA && intl) |=> state == CS_ACK);
    // R5: programmed wait states never apply to an internal hit
    assert_int_no_ws_R5: assert property (@(posedge clk) disable iff (rst)
        (state == CS_WS) |-> !intl);
    // R6: WAIT holds an external data phase
    assert_wait_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state == CS_DATA && !intl && ext_wait) |=> state == CS_DATA);
endmodule

// File: rtl/iocyc_arbiter.sv
module iocyc_arbiter
    import iocyc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_page0,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [WS_W-1:0]   wait_cnt,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              base_wr,
    input  logic [BASE_W-1:0] base_wdata,
    output logic              reg_sel,
    output logic              reg_we,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              ext_cyc,
    output logic              ext_write,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic [DATA_W-1:0] ext_rdata,
    input  logic              ext_wait
);
    logic [ADDR_W-1:0] eff_addr;
    logic              hit;
    logic              accept;
    cyc_state_e        state;
    io_req_t           req_q;
    logic [DATA_W-1:0] rsp_q;

    iocyc_window u_window (
        .clk        (clk),
        .rst        (rst),
        .base_wr    (base_wr),
        .base_wdata (base_wdata),
        .raw_addr   (req_addr),
        .page0      (req_page0),
        .eff_addr   (eff_addr),
        .hit        (hit)
    );

    assign accept = req_valid && (state == CS_IDLE);

    iocyc_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .intl     (req_q.intl),
        .ws       (req_q.ws),
        .ext_wait (ext_wait),
        .state    (state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (accept) begin
            req_q.wr    <= req_write;
            req_q.intl  <= hit;
            req_q.ws    <= wait_cnt;
            req_q.addr  <= eff_addr;
            req_q.wdata <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                    rsp_q <= '0;
        else if (state == CS_DATA)  rsp_q <= req_q.intl ? reg_rdata : ext_rdata;
    end

    always_comb begin
        ext_cyc   = (state == CS_LEAD) || (state == CS_WS) || (state == CS_DATA);
        ext_write = ext_cyc && req_q.wr;
        ext_addr  = req_q.addr;
        ext_wdata = req_q.wdata;
        reg_sel   = (state == CS_DATA) && req_q.intl;
        reg_we    = reg_sel && req_q.wr;
        reg_idx   = req_q.addr[IDX_W-1:0];
        reg_wdata = req_q.wdata;
        req_ready = (state == CS_ACK);
        rsp_rdata = rsp_q;
    end

    // R7: one completion pulse per cycle
    assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready);
    // R3: register strobe is a single cycle
    assert_sel_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        reg_sel |=> !reg_sel);
    // R3: every register strobe is mirrored on the bus
    assert_sel_mirrored_R3: assert property (@(posedge clk) disable iff (rst)
        reg_sel |-> ext_cyc);
    // R8: decode decision frozen for the life of a cycle
    assert_decode_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (state != CS_IDLE) |=> (state == CS_IDLE || $stable(req_q.intl)));
    // R9: quiet bus when idle
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (state == CS_IDLE) |-> (!ext_cyc && !reg_sel && !req_ready));
endmodule

// File: tb/sim_iocyc_arbiter.sv
`timescale 1ns/1ps
module sim_iocyc_arbiter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_page0 = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [1:0]  wait_cnt = '0;
    logic        req_ready;
    logic [7:0]  rsp_rdata;
    logic        base_wr = 1'b0;
    logic [1:0]  base_wdata = '0;
    logic        reg_sel, reg_we;
    logic [5:0]  reg_idx;
    logic [7:0]  reg_wdata, reg_rdata;
    logic        ext_cyc, ext_write;
    logic [15:0] ext_addr;
    logic [7:0]  ext_wdata, ext_rdata;
    logic        ext_wait;

    always #2 clk = ~clk;

    iocyc_arbiter u0 (.*);

    // peripheral stub
    logic [7:0] pregs [64];
    assign reg_rdata = pregs[reg_idx];
    always @(posedge clk) if (reg_sel && reg_we) pregs[reg_idx] <= reg_wdata;

    // external bus stub
    int cyc_n = 0;
    int wait_hi = 0;
    assign ext_rdata = ext_addr[7:0] ^ 8'h5A;
    assign ext_wait  = ext_cyc && (cyc_n < wait_hi);
    always @(posedge clk) cyc_n <= ext_cyc ? cyc_n + 1 : 0;

    int total = 0, bad = 0;
    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    typedef struct {
        bit          wr;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic [7:0]  rdata;
        int          lat;
        bit          intl;
        string       req;
    } item_t;
    item_t sb[$];
    item_t mon_it;

    logic [7:0] shadow [64];
    logic [1:0] sh_base = 2'd0;

    task automatic do_io(input bit wr, input logic [15:0] addr, input bit pg0,
                         input logic [7:0] wd, input int ws, input int k,
                         input int mid_base, input string req);
        item_t it;
        logic [15:0] ea;
        ea = pg0 ? {8'h00, addr[7:0]} : addr;
        it.wr = wr; it.addr = ea; it.wdata = wd; it.req = req;
        it.intl = (ea[15:8] == 8'h00) && (ea[7:6] == sh_base);
        it.lat = it.intl ? 3 : 3 + ws + k;
        it.rdata = it.intl ? shadow[ea[5:0]] : (ea[7:0] ^ 8'h5A);
        if (wr && it.intl) shadow[ea[5:0]] = wd;
        sb.push_back(it);
        @(negedge clk);
        req_write = wr; req_addr = addr; req_page0 = pg0; req_wdata = wd;
        wait_cnt = ws[1:0]; wait_hi = 1 + ws + k;
        req_valid = 1'b1;
        if (mid_base >= 0) begin
            @(negedge clk);
            base_wr = 1'b1; base_wdata = mid_base[1:0];
            @(negedge clk);
            base_wr = 1'b0;
            sh_base = mid_base[1:0];
        end
        do @(negedge clk); while (!req_ready);
        req_valid = 1'b0;
    endtask

    // monitor / scoreboard
    int lat_n = 0, sel_n = 0;
    bit saw_ext = 0, ext_bad = 0, sel_bad = 0;
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            if (req_valid) lat_n++;
            if (ext_cyc) begin
                saw_ext = 1;
                if (sb.size() > 0 && (ext_addr !== sb[0].addr || ext_write !== sb[0].wr ||
                    (sb[0].wr && ext_wdata !== sb[0].wdata))) ext_bad = 1;
            end
            if (reg_sel) begin
                sel_n++;
                if (sb.size() > 0 && (reg_idx !== sb[0].addr[5:0] || reg_we !== sb[0].wr ||
                    (sb[0].wr && reg_wdata !== sb[0].wdata))) sel_bad = 1;
            end
            if (req_ready) begin
                if (sb.size() == 0) begin
                    chk(0, "R7", "ready with no request", 1, 0);
                end else begin
                    mon_it = sb.pop_front();
                    chk(lat_n == mon_it.lat, mon_it.req, "latency", lat_n, mon_it.lat);
                    chk(sel_n == (mon_it.intl ? 1 : 0) && !sel_bad, mon_it.req,
                        "register strobes", sel_n, mon_it.intl ? 1 : 0);
                    chk(saw_ext && !ext_bad, mon_it.req, "mirrored bus cycle",
                        {30'd0, saw_ext, ext_bad}, 2);
                    if (!mon_it.wr)
                        chk(rsp_rdata === mon_it.rdata, mon_it.req, "read data",
                            rsp_rdata, mon_it.rdata);
                end
                lat_n = 0; sel_n = 0; saw_ext = 0; ext_bad = 0; sel_bad = 0;
            end
        end
    end

    initial begin
        repeat (4000) @(posedge clk);
        bad++; total++;
        $display("FAIL R7 watchdog: ready never arrived actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            pregs[i]  = 8'h80 + 8'(i);
            shadow[i] = 8'h80 + 8'(i);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!req_ready && !ext_cyc && !reg_sel, "R9", "reset outputs",
            {29'd0, req_ready, ext_cyc, reg_sel}, 0);

        do_io(0, 16'h0005, 0, 8'h00, 2, 3, -1, "R4");  // internal read, base 0 from reset, WAIT ignored (R5)
        do_io(1, 16'h0012, 0, 8'h3C, 3, 4, -1, "R3");  // internal write mirrored, R5 fixed length
        do_io(0, 16'h0012, 0, 8'h00, 0, 0, -1, "R3");  // readback of written register
        do_io(0, 16'h1234, 0, 8'h00, 0, 0, -1, "R6");  // external, no waits
        do_io(0, 16'h0145, 0, 8'h00, 2, 0, -1, "R1");  // upper byte nonzero: external
        do_io(1, 16'h2212, 0, 8'hC3, 1, 2, -1, "R6");  // external write aliasing index 0x12
        do_io(0, 16'h0012, 0, 8'h00, 0, 0, -1, "R6");  // register unchanged by external write
        do_io(0, 16'h7F05, 1, 8'h00, 3, 2, -1, "R2");  // page-zero makes it internal
        do_io(0, 16'h0045, 0, 8'h00, 1, 1, -1, "R1");  // relocation bits mismatch: external
        do_io(0, 16'h0003, 0, 8'h00, 0, 5, 1, "R8");   // base rewritten mid-cycle, still internal
        do_io(0, 16'h0045, 0, 8'h00, 0, 0, -1, "R8");  // new base now selects 0x40 window
        do_io(0, 16'h0003, 0, 8'h00, 2, 1, -1, "R1");  // old window now external
        do_io(1, 16'hAB50, 1, 8'h77, 0, 0, -1, "R2");  // page-zero write into relocated window
        do_io(0, 16'h0050, 0, 8'h00, 0, 0, -1, "R3");  // readback
        do_io(0, 16'h3001, 0, 8'h00, 3, 5, -1, "R6");  // longest external stretch
        repeat (3) @(negedge clk);
        chk(!req_ready && !ext_cyc, "R7", "quiet after last cycle",
            {30'd0, req_ready, ext_cyc}, 0);
        chk(sb.size() == 0, "R7", "unanswered requests", sb.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule